// File: doc/BRIEF.md
# Write-Leveling Delay Recovery Unit

After a write-leveling pass, the PHY reports a raw per-lane delay that is relative to the seed it was started from. This block rebuilds the true write-DQS delay for one byte lane per strobe by combining that raw value with the stored seed. When seed-adjust mode is on, the seed's gross field was rewritten before training with a pre-gross offset of one or two gross steps, chosen by the parity of the gross field. The block removes that offset again. Results that fall below zero are either clamped to zero or kept as signed values, depending on a mode bit.

Across the lanes of a channel, the block keeps the most negative recovered delay that qualifies as a critical candidate. A software sequencer uses that value later to shift the whole channel. The block also raises a sticky flag when a recovered delay lands more than one gross step away from its seed. The sequencer strobes one lane per cycle. It pulses a channel-start input before the first lane of each channel, and it clears the flag when it has read it.

Top module: `wl_result_recover`

## Requirements
- R1: `dly_vld` is high exactly in the cycle after a cycle with `lane_vld` high, and `dly_out` then carries that lane's recovered delay. Without a strobe, `dly_out` holds its value. `dly_out` is two's complement, `DLY_W+2` bits wide. Seed and measured delay are `DLY_W` bits, and the gross field is the top three bits (bits 7:5 at the default width of 8). One gross step is 0x20.
- R2: With seed-adjust on and seed bit 5 set, the result is measured + (seed & 0xE0) − 0x20. If negative delays are allowed and seed bit 7 is also set, the result is instead measured − 0x40, and it is a critical candidate.
- R3: With seed-adjust on, seed bit 5 clear, seed gross 0 and measured below 0x40, the result is 0 when negative delays are not allowed. When they are allowed, the result is measured − 0x40 and it is a critical candidate.
- R4: With seed-adjust on and seed bit 5 clear in every other case, the result is measured + (seed & 0xE0) − 0x40. It is a critical candidate only when write-DQ-early mode is set.
- R5: With seed-adjust off, the result is the measured value. The exception is a seed gross of 0 with a measured gross of 3, which yields 0. Such results are never critical candidates.
- R6: `crit_dly` holds the minimum signed value among 0 and the critical candidates strobed since the last `chan_start`. A `chan_start` clears it to 0, and a candidate strobed in the same cycle is still taken into account.
- R7: When negative delays are not allowed, a strobed lane whose result exceeds seed + 0x20, or whose seed exceeds result + 0x20, sets `oor_flag`. The flag stays set until `oor_clr`. A new violation in the same cycle as `oor_clr` wins.
- R8: During reset, `dly_vld`, `dly_out`, `crit_dly` and `oor_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_start | input | 1 | Restart critical-delay tracking for a new channel |
| oor_clr | input | 1 | Clear the sticky out-of-range flag |
| lane_vld | input | 1 | Seed and measured delay of one lane are valid |
| seed | input | DLY_W | Seed the lane was trained from |
| meas | input | DLY_W | Raw delay reported by the PHY |
| seed_adj | input | 1 | Seed-adjust (pre-gross) encoding in use |
| neg_ok | input | 1 | Negative delays may be carried |
| dq_early | input | 1 | Write-DQ-early mode |
| dly_vld | output | 1 | `dly_out` updated this cycle |
| dly_out | output | DLY_W+2 | Recovered signed delay |
| crit_dly | output | DLY_W+2 | Most negative critical delay of the channel |
| oor_flag | output | 1 | Sticky seed-window violation |

## Verification
Directed lanes walk each recovery branch. They use odd and even seed gross values, seeds with bit 7 set and clear, and measured values on both sides of 0x40 and in gross 3. This separates the two pre-gross offsets, the clamp from the signed path, and the gross-3 rounding. Further patterns pair `chan_start` with and without a same-cycle candidate, positive and negative candidates, and `oor_clr` alone and together with a new violation. These patterns tell reset ordering apart from set and clear priority. A long run of random seeds, measurements and mode bits then covers branch boundaries and the window compare at both edges. A cycle-accurate behavioural model checks every output on every clock.

// File: rtl/wlr_pkg.sv
package wlr_pkg;

   typedef struct packed {
      logic seed_adj;
      logic neg_en;
      logic dq_early;
   } wlr_mode_t;

endpackage

// File: rtl/wlr_recover_calc.sv
module wlr_recover_calc
   import wlr_pkg::*;
#(
   parameter int DLY_W = 8
) (
   input  logic [DLY_W-1:0]        seed,
   input  logic [DLY_W-1:0]        meas,
   input  wlr_mode_t               mode,
   output logic signed [DLY_W+1:0] result,
   output logic                    cand
);
   localparam int RES_W = DLY_W + 2;
   localparam int GL    = DLY_W - 3;
   localparam logic signed [RES_W-1:0] K_ONE = RES_W'(1 << GL);
   localparam logic signed [RES_W-1:0] K_TWO = RES_W'(2 << GL);

   logic signed [RES_W-1:0] s_meas;
   logic signed [RES_W-1:0] s_gmask;
   logic                    seed_g_zero;
   logic                    meas_g_three;
   logic                    meas_below_two;

   always_comb begin
      s_meas         = {2'b00, meas};
      s_gmask        = {2'b00, seed[DLY_W-1:GL], {GL{1'b0}}};
      seed_g_zero    = (seed[DLY_W-1:GL] == 3'd0);
      meas_g_three   = (meas[DLY_W-1:GL] == 3'd3);
      meas_below_two = (meas[DLY_W-1:GL+1] == 2'd0);
   end

   always_comb begin
      result = s_meas;
      cand   = 1'b0;
      if (mode.seed_adj) begin
         if (seed[GL]) begin
            if (mode.neg_en && seed[DLY_W-1]) begin
               result = s_meas - K_TWO;
               cand   = 1'b1;
            end else begin
               result = s_meas + s_gmask - K_ONE;
            end
         end else if (seed_g_zero && meas_below_two) begin
            if (mode.neg_en) begin
               result = s_meas - K_TWO;
               cand   = 1'b1;
            end else begin
               result = '0;
            end
         end else begin
            result = s_meas + s_gmask - K_TWO;
            cand   = mode.dq_early;
         end
      end else if (seed_g_zero && meas_g_three) begin
         result = '0;
      end
   end

endmodule

// File: rtl/wlr_crit_track.sv
module wlr_crit_track #(
   parameter int DLY_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    chan_start,
   input  logic                    cand_vld,
   input  logic signed [DLY_W+1:0] cand_val,
   output logic signed [DLY_W+1:0] crit
);
   localparam int RES_W = DLY_W + 2;

   logic signed [RES_W-1:0] crit_q;
   logic                    cand_neg;
   logic                    cand_lower;

   always_comb begin
      cand_neg   = cand_vld && (cand_val < 0);
      cand_lower = cand_vld && (cand_val < crit_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         crit_q <= '0;
      end else if (chan_start) begin
         crit_q <= cand_neg ? cand_val : '0;
      end else if (cand_lower) begin
         crit_q <= cand_val;
      end
   end

   assign crit = crit_q;

   AST_CRIT_NONPOS: assert property (@(posedge clk) disable iff (!rst_n)
      crit_q <= 0); // R6

   AST_CRIT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_start |=> crit_q <= $past(crit_q)); // R6

endmodule

// File: rtl/wlr_range_check.sv
module wlr_range_check #(
   parameter int DLY_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    hit,
   input  logic                    neg_en,
   input  logic                    clr,
   input  logic signed [DLY_W+1:0] result,
   input  logic [DLY_W-1:0]        seed,
   output logic                    flag
);
   localparam int EW = DLY_W + 3;
   localparam int GL = DLY_W - 3;
   localparam logic signed [EW-1:0] K_WIN = EW'(1 << GL);

   logic signed [EW-1:0] r_x;
   logic signed [EW-1:0] s_x;
   logic                 viol;
   logic                 set_now;
   logic                 flag_q;

   always_comb begin
      r_x     = {result[DLY_W+1], result};
      s_x     = {3'b000, seed};
      viol    = (r_x > (s_x + K_WIN)) || (s_x > (r_x + K_WIN));
      set_now = hit && !neg_en && viol;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (set_now) flag_q <= 1'b1;
      else if (clr)     flag_q <= 1'b0;
   end

   assign flag = flag_q;

   AST_OOR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q && !clr |=> flag_q); // R7

   AST_OOR_NEEDS_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> !$rose(flag_q)); // R7

endmodule

// File: rtl/wl_result_recover.sv
module wl_result_recover
   import wlr_pkg::*;
#(
   parameter int DLY_W       = 8,
   parameter bit NEG_CAPABLE = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    chan_start,
   input  logic                    oor_clr,
   input  logic                    lane_vld,
   input  logic [DLY_W-1:0]        seed,
   input  logic [DLY_W-1:0]        meas,
   input  logic                    seed_adj,
   input  logic                    neg_ok,
   input  logic                    dq_early,
   output logic                    dly_vld,
   output logic signed [DLY_W+1:0] dly_out,
   output logic signed [DLY_W+1:0] crit_dly,
   output logic                    oor_flag
);
   localparam int RES_W = DLY_W + 2;
   localparam int GL    = DLY_W - 3;

   if (DLY_W < 4) begin : g_bad_width
      $error("wl_result_recover: DLY_W must be at least 4");
   end

   logic                    neg_en;
   wlr_mode_t               mode;
   logic signed [RES_W-1:0] result;
   logic                    cand;
   logic                    vld_q;
   logic signed [RES_W-1:0] dly_q;

   if (NEG_CAPABLE) begin : g_neg_on
      assign neg_en = neg_ok;
   end else begin : g_neg_off
      assign neg_en = 1'b0;
   end

   assign mode = '{seed_adj: seed_adj, neg_en: neg_en, dq_early: dq_early};

   wlr_recover_calc #(.DLY_W(DLY_W)) u_calc (
      .seed   (seed),
      .meas   (meas),
      .mode   (mode),
      .result (result),
      .cand   (cand)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         dly_q <= '0;
      end else begin
         vld_q <= lane_vld;
         if (lane_vld) dly_q <= result;
      end
   end

   wlr_crit_track #(.DLY_W(DLY_W)) u_crit (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_start (chan_start),
      .cand_vld   (lane_vld && cand),
      .cand_val   (result),
      .crit       (crit_dly)
   );

   wlr_range_check #(.DLY_W(DLY_W)) u_range (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (lane_vld),
      .neg_en (neg_en),
      .clr    (oor_clr),
      .result (result),
      .seed   (seed),
      .flag   (oor_flag)
   );

   assign dly_vld = vld_q;
   assign dly_out = dly_q;

   AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      lane_vld |=> dly_vld); // R1

   AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_vld |=> !dly_vld && $stable(dly_out)); // R1

   AST_CLAMP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      lane_vld && seed_adj && !seed[GL] && (seed[DLY_W-1:GL] == 3'd0)
      && (meas[DLY_W-1:GL+1] == 2'd0) && !neg_en |=> dly_out == 0); // R3

   AST_NEG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      lane_vld && !neg_en |=> dly_out >= 0); // R2

endmodule

// File: tb/sim_wl_result_recover.sv
module sim_wl_result_recover;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              chan_start = 1'b0;
   logic              oor_clr = 1'b0;
   logic              lane_vld = 1'b0;
   logic [7:0]        seed = '0;
   logic [7:0]        meas = '0;
   logic              seed_adj = 1'b0;
   logic              neg_ok = 1'b0;
   logic              dq_early = 1'b0;
   logic              dly_vld;
   logic signed [9:0] dly_out;
   logic signed [9:0] crit_dly;
   logic              oor_flag;

   int n_cmp = 0;
   int n_bad = 0;
   int e_vld = 0, e_dly = 0, e_crit = 0, e_oor = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wl_result_recover u0 (
      .clk(clk), .rst_n(rst_n), .chan_start(chan_start), .oor_clr(oor_clr),
      .lane_vld(lane_vld), .seed(seed), .meas(meas), .seed_adj(seed_adj),
      .neg_ok(neg_ok), .dq_early(dq_early), .dly_vld(dly_vld), .dly_out(dly_out),
      .crit_dly(crit_dly), .oor_flag(oor_flag)
   );

   function automatic int ref_res(int s, int m, bit sa, bit na, bit ea, output bit c);
      c = 1'b0;
      if (sa) begin
         if ((s & 32) != 0) begin
            if (na && (s & 128) != 0) begin c = 1'b1; return m - 64; end
            return m + (s & 224) - 32;
         end
         if ((s & 224) == 0 && m < 64) begin
            if (na) begin c = 1'b1; return m - 64; end
            return 0;
         end
         c = ea;
         return m + (s & 224) - 64;
      end
      if ((s >> 5) == 0 && (m >> 5) == 3) return 0;
      return m;
   endfunction

   task automatic cmp(string req, string what, int got, int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
      end
   endtask

   task automatic check_all(string req);
      int got_dly;
      int got_crit;
      got_dly  = dly_out;
      got_crit = crit_dly;
      cmp("R1", "dly_vld", int'(dly_vld), e_vld);
      cmp(req, "dly_out", got_dly, e_dly);
      cmp("R6", "crit_dly", got_crit, e_crit);
      cmp("R7", "oor_flag", int'(oor_flag), e_oor);
   endtask

   // drive one cycle of stimulus at a negedge, advance the model, compare at the next negedge
   task automatic step(bit v, int s, int m, bit sa, bit na, bit ea, bit cs, bit cl, string req);
      bit c;
      int r;
      lane_vld = v; seed = 8'(s); meas = 8'(m);
      seed_adj = sa; neg_ok = na; dq_early = ea;
      chan_start = cs; oor_clr = cl;
      r = ref_res(s, m, sa, na, ea, c);
      e_vld = v;
      if (v) e_dly = r;
      if (cs) e_crit = (v && c && r < 0) ? r : 0;
      else if (v && c && r < e_crit) e_crit = r;
      if (v && !na && (r > s + 32 || s > r + 32)) e_oor = 1;
      else if (cl) e_oor = 0;
      @(negedge clk);
      check_all(req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check_all("R8");
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R8");

      // R5: seed-adjust off
      step(1, 8'h10, 8'h65, 0, 0, 0, 0, 0, "R5");
      step(1, 8'h10, 8'h45, 0, 0, 0, 0, 0, "R5");
      step(1, 8'h30, 8'h65, 0, 0, 0, 0, 0, "R5");
      step(1, 8'h10, 8'h65, 0, 1, 1, 0, 0, "R5");
      // R1: hold while idle
      step(0, 8'hFF, 8'h00, 1, 1, 1, 0, 0, "R1");
      step(0, 8'h00, 8'hFF, 0, 0, 0, 0, 0, "R1");
      // R7: clear
      step(0, 8'h00, 8'h00, 0, 0, 0, 0, 1, "R7");
      // R2: odd gross
      step(1, 8'h35, 8'h22, 1, 0, 0, 0, 0, "R2");
      step(1, 8'hA5, 8'h10, 1, 1, 0, 0, 0, "R2");
      step(1, 8'hA5, 8'h10, 1, 0, 0, 0, 0, "R2");
      step(1, 8'h25, 8'h3F, 1, 1, 1, 0, 0, "R2");
      // R3: even gross zero, low measurement
      step(1, 8'h05, 8'h30, 1, 0, 0, 0, 0, "R3");
      step(1, 8'h05, 8'h30, 1, 1, 0, 0, 0, "R3");
      step(1, 8'h00, 8'h00, 1, 1, 0, 0, 0, "R3");
      step(1, 8'h1F, 8'h3F, 1, 0, 1, 0, 0, "R3");
      // R4: even gross, other cases
      step(1, 8'h45, 8'h50, 1, 0, 0, 0, 0, "R4");
      step(1, 8'h05, 8'h45, 1, 0, 1, 0, 0, "R4");
      step(1, 8'h00, 8'h40, 1, 1, 1, 0, 0, "R4");
      step(1, 8'hC0, 8'h01, 1, 1, 1, 0, 0, "R4");
      // R6: channel restart
      step(0, 8'h00, 8'h00, 0, 0, 0, 1, 0, "R6");
      step(1, 8'h05, 8'h20, 1, 1, 0, 1, 0, "R6");
      step(1, 8'h05, 8'h30, 1, 1, 0, 0, 0, "R6");
      step(1, 8'h05, 8'h38, 1, 1, 0, 1, 0, "R6");
      // R7: window edges and set-over-clear
      step(0, 8'h00, 8'h00, 0, 0, 0, 0, 1, "R7");
      step(1, 8'h40, 8'h60, 0, 0, 0, 0, 0, "R7");
      step(1, 8'h40, 8'h61, 0, 0, 0, 0, 1, "R7");
      step(1, 8'h40, 8'h20, 0, 0, 0, 0, 1, "R7");
      step(1, 8'h40, 8'h1F, 0, 0, 0, 0, 0, "R7");
      step(1, 8'h40, 8'h1F, 0, 1, 0, 0, 1, "R7");

      for (int i = 0; i < 4000; i++) begin
         step(($urandom % 4) != 0, int'($urandom % 256), int'($urandom % 256),
              ($urandom % 4) != 0, $urandom % 2 == 1, $urandom % 2 == 1,
              ($urandom % 16) == 0, ($urandom % 8) == 0, "R4");
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule